// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Engine

This block models, at the pin level, a small serial EEPROM that is addressed over a three-wire select/clock/data link. A host raises chip select and clocks a command in on the data input. The command is a start bit of 1, a two-bit opcode, an address and, for some commands, a data word. The engine then reads from or programs an internal byte array. Read data comes back on the data output with automatic address increment. Programming is self-timed by a counter in the system clock domain. While programming runs, and until the host sends the next start bit, the data output reports ready/busy.

The word width is chosen by a static mode pin. In 16-bit mode there are 512 words and 9 address bits. In 8-bit mode there are 1024 bytes and 10 address bits. Program times are parameters in system clock cycles: one for single-word write or erase, one for erase-all and one for write-all. The serial clock is oversampled by the system clock, and all of its actions happen on its rising edge. The link has no flow control. The host paces every transfer with the serial clock, and the link is plain control pins rather than a streaming handshake.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the array reads all ones, writes are disabled, no program cycle is running and the data output is not driven.
- R2: A read (start 1, opcode 10, address) drives a 0 on data-out at the serial-clock rising edge that takes the last address bit. Each later rising edge then drives one bit of the addressed word, most significant first: 16 bits in 16-bit mode (mode pin 1) and 8 bits in 8-bit mode (mode pin 0).
- R3: If chip select stays high and the clock keeps running after a read, the next words follow with no gap and no extra 0 bit. The address wraps from the top word to word 0.
- R4: A write (opcode 01, address, data word most significant first) stores the word when writes are enabled. While chip select is high, data-out shows 0 during the program cycle and 1 once it is done.
- R5: An erase (opcode 11, address) sets every bit of the addressed word to 1 when writes are enabled.
- R6: Extended opcode 00 with selector 10 in the top two address bits (erase-all) sets the whole array to ones. The address bits below the selector have no effect.
- R7: Extended opcode 00 with selector 01 (write-all) takes one data word and writes it to every word of the array.
- R8: Selector 11 enables writes and selector 00 disables them. While writes are disabled, write, erase, erase-all and write-all leave the array unchanged and start no busy period.
- R9: Chip select low puts data-out in high impedance and drops a partly received command. It does not stop a program cycle that has already started, and busy shows again when chip select returns high.
- R10: During a program cycle all serial-clock edges and data bits are ignored.
- R11: After programming ends, ready (1) stays on data-out and leading 0 bits are ignored. The next start bit takes data-out off the line.
- R12: The busy period lasts the word, erase-all or write-all duration parameter, counted from the clock edge that takes the last input bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Active-low asynchronous reset |
| org16 | input | 1 | Static mode pin: 1 = 16-bit words, 0 = 8-bit words |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; all actions on its rising edge |
| di | input | 1 | Serial data input |
| do_o | output | 1 | Serial data output (read data or ready/busy) |
| do_oe | output | 1 | Output enable for data-out; low means high impedance |

## Verification
Assertions check on every cycle the properties that need no scenario. A program cycle starts only when writes are enabled and never on top of a running one. The countdown loads and steps by exactly one. The whole-array sweep stays inside the busy window. A read decode is followed by the 0 bit on data-out, and a falling chip select starts no program strobe. Other behaviour only shows through bench scenarios: the stored contents and the address wrap in sequential reads, the don't-care bits of erase-all, a command clocked in during a program cycle being ignored, and the hold of ready status until a start bit.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ
  } mw_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EX_WDIS  = 2'b00;
  localparam logic [1:0] EX_WRALL = 2'b01;
  localparam logic [1:0] EX_ERALL = 2'b10;
  localparam logic [1:0] EX_WEN   = 2'b11;
endpackage

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] dur,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= dur;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == $past(dur)));
  p_countdown_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          org16,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_word,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_val,
  input  logic          fill_start,
  input  logic [15:0]   fill_val,
  output logic          filling
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] sp;
  logic [7:0]    fill_hi, fill_lo;

  // 16-bit words occupy an even/odd byte pair, high byte at the even slot
  always_comb begin
    if (org16) rd_word = {mem[{rd_addr[AW-2:0], 1'b0}], mem[{rd_addr[AW-2:0], 1'b1}]};
    else       rd_word = {mem[rd_addr], 8'h00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      sp      <= '0;
      filling <= 1'b0;
      fill_hi <= 8'hFF;
      fill_lo <= 8'hFF;
    end else if (fill_start) begin
      filling <= 1'b1;
      sp      <= '0;
      fill_hi <= org16 ? fill_val[15:8] : fill_val[7:0];
      fill_lo <= fill_val[7:0];
    end else if (filling) begin
      mem[sp] <= sp[0] ? fill_lo : fill_hi;
      sp      <= sp + 1'b1;
      if (sp == '1) filling <= 1'b0;
    end else if (wr_en) begin
      if (org16) begin
        mem[{wr_addr[AW-2:0], 1'b0}] <= wr_val[15:8];
        mem[{wr_addr[AW-2:0], 1'b1}] <= wr_val[7:0];
      end else begin
        mem[wr_addr] <= wr_val[7:0];
      end
    end
  end

  p_no_word_write_in_sweep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    filling |-> !wr_en);
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int AW8    = 10,
  parameter int T_WORD = 200,
  parameter int T_ERAL = 2048,
  parameter int T_WRAL = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org16,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int AW16 = AW8 - 1;
  localparam int TMAX = (T_WRAL > T_ERAL) ? ((T_WRAL > T_WORD) ? T_WRAL : T_WORD)
                                          : ((T_ERAL > T_WORD) ? T_ERAL : T_WORD);
  localparam int CW   = $clog2(TMAX + 1);

  mw_state_e     st;
  logic          sk_q, rise, busy, filling;
  logic [1:0]    op, ext;
  logic [4:0]    cnt, rd_cnt, aw_len, dw_len;
  logic [AW8-1:0] addr_sh, addr_nx, addr_in, ptr, ptr_inc, rd_addr;
  logic [15:0]   data_sh, data_nx, rd_sh, rd_word;
  logic          do_r, wen, show;
  logic          tstart, wr_en, fill_start;
  logic [CW-1:0] tdur;
  logic [15:0]   wr_val, fill_val;
  logic          last_addr, last_data;

  assign rise      = cs & sk & ~sk_q & ~busy & ~tstart;
  assign aw_len    = org16 ? 5'(AW16) : 5'(AW8);
  assign dw_len    = org16 ? 5'd16 : 5'd8;
  assign addr_nx   = {addr_sh[AW8-2:0], di};
  assign addr_in   = org16 ? {1'b0, addr_nx[AW16-1:0]} : addr_nx;
  assign ext       = org16 ? addr_nx[AW16-1 -: 2] : addr_nx[AW8-1 -: 2];
  assign data_nx   = {data_sh[14:0], di};
  assign ptr_inc   = org16 ? {1'b0, ptr[AW16-1:0] + 1'b1} : ptr + 1'b1;
  assign rd_addr   = (st == ST_READ) ? ptr_inc : addr_in;
  assign last_addr = rise && (st == ST_ADDR) && (cnt == aw_len - 5'd1);
  assign last_data = rise && (st == ST_DATA) && (cnt == dw_len - 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q <= 1'b0;
      st <= ST_IDLE;
      op <= OP_EXT;
      cnt <= '0;
      rd_cnt <= '0;
      addr_sh <= '0;
      data_sh <= '0;
      rd_sh <= '0;
      ptr <= '0;
      do_r <= 1'b0;
      wen <= 1'b0;
      show <= 1'b0;
      tstart <= 1'b0;
      tdur <= '0;
      wr_en <= 1'b0;
      wr_val <= '0;
      fill_start <= 1'b0;
      fill_val <= '0;
    end else begin
      sk_q <= sk;
      tstart <= 1'b0;
      wr_en <= 1'b0;
      fill_start <= 1'b0;
      if (!cs) begin
        st <= ST_IDLE;
        if (!busy && !tstart) show <= 1'b0;
      end else if (rise) begin
        case (st)
          ST_IDLE: if (di) begin
            st <= ST_OPC;
            cnt <= '0;
            show <= 1'b0;
          end
          ST_OPC: begin
            op <= {op[0], di};
            if (cnt == 5'd1) begin
              st <= ST_ADDR;
              cnt <= '0;
            end else cnt <= cnt + 5'd1;
          end
          ST_ADDR: begin
            addr_sh <= addr_nx;
            cnt <= cnt + 5'd1;
            if (cnt == aw_len - 5'd1) begin
              cnt <= '0;
              ptr <= addr_in;
              case (op)
                OP_READ: begin
                  st <= ST_READ;
                  rd_sh <= rd_word;
                  rd_cnt <= dw_len;
                  do_r <= 1'b0;
                end
                OP_WRITE: st <= ST_DATA;
                OP_ERASE: begin
                  st <= ST_IDLE;
                  if (wen) begin
                    wr_en <= 1'b1;
                    wr_val <= 16'hFFFF;
                    tstart <= 1'b1;
                    tdur <= CW'(T_WORD);
                    show <= 1'b1;
                  end
                end
                default: begin
                  st <= ST_IDLE;
                  case (ext)
                    EX_WEN:  wen <= 1'b1;
                    EX_WDIS: wen <= 1'b0;
                    EX_ERALL: if (wen) begin
                      fill_start <= 1'b1;
                      fill_val <= 16'hFFFF;
                      tstart <= 1'b1;
                      tdur <= CW'(T_ERAL);
                      show <= 1'b1;
                    end
                    default: st <= ST_DATA;
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            data_sh <= data_nx;
            cnt <= cnt + 5'd1;
            if (cnt == dw_len - 5'd1) begin
              st <= ST_IDLE;
              if (wen) begin
                tstart <= 1'b1;
                show <= 1'b1;
                if (op == OP_WRITE) begin
                  wr_en <= 1'b1;
                  wr_val <= data_nx;
                  tdur <= CW'(T_WORD);
                end else begin
                  fill_start <= 1'b1;
                  fill_val <= data_nx;
                  tdur <= CW'(T_WRAL);
                end
              end
            end
          end
          ST_READ: begin
            if (rd_cnt == '0) begin
              ptr <= ptr_inc;
              do_r <= rd_word[15];
              rd_sh <= {rd_word[14:0], 1'b0};
              rd_cnt <= dw_len - 5'd1;
            end else begin
              do_r <= rd_sh[15];
              rd_sh <= {rd_sh[14:0], 1'b0};
              rd_cnt <= rd_cnt - 5'd1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign do_oe = cs & ((st == ST_READ) | show);
  assign do_o  = do_oe & ((st == ST_READ) ? do_r : ~(busy | tstart));

  mw_array #(.AW(AW8)) u_arr (
    .clk(clk), .rst_n(rst_n), .org16(org16),
    .rd_addr(rd_addr), .rd_word(rd_word),
    .wr_en(wr_en), .wr_addr(ptr), .wr_val(wr_val),
    .fill_start(fill_start), .fill_val(fill_val), .filling(filling)
  );

  mw_prog_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tstart), .dur(tdur), .busy(busy)
  );

  p_prog_needs_wen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tstart |-> wen);
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tstart |-> !busy);
  p_sweep_in_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    filling |-> busy);
  p_dummy_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (last_addr && op == OP_READ) |=> (!cs || (do_oe && !do_o)));
  p_abort_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs) |=> (!wr_en && !fill_start && !tstart));
  p_data_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_data && wen) |=> tstart);
endmodule

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
  localparam int AW8 = 10;
  localparam int TW = 200;
  localparam int TE = 1100;
  localparam int TA = 2200;

  logic clk = 1'b0, rst_n = 1'b0, org16 = 1'b1, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] m [1 << AW8];
  bit wen_m = 0;

  always #2 clk = ~clk;

  mw_eeprom #(.AW8(AW8), .T_WORD(TW), .T_ERAL(TE), .T_WRAL(TA)) u_dut (
    .clk(clk), .rst_n(rst_n), .org16(org16), .cs(cs), .sk(sk), .di(di),
    .do_o(do_o), .do_oe(do_oe));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int aw(); return org16 ? 9 : 10; endfunction
  function automatic int dw(); return org16 ? 16 : 8; endfunction

  function automatic logic [15:0] exp_word(input int a);
    int w;
    if (org16) begin
      w = a & 511;
      return {m[2*w], m[2*w+1]};
    end
    return {8'h00, m[a & 1023]};
  endfunction

  task automatic put_word(input int a, input logic [15:0] d);
    if (org16) begin
      m[2*(a & 511)] = d[15:8];
      m[2*(a & 511)+1] = d[7:0];
    end else m[a & 1023] = d[7:0];
  endtask

  task automatic bit_io(input logic b, output logic dout, output logic oe);
    di = b;
    repeat (2) @(negedge clk);
    sk = 1'b1;
    repeat (3) @(negedge clk);
    dout = do_o;
    oe = do_oe;
    sk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sel();
    @(negedge clk);
    cs = 1'b1;
    @(negedge clk);
  endtask

  task automatic desel();
    cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic header(input logic [1:0] op, input int addr, output logic dout, output logic oe);
    logic d, o;
    bit_io(1'b1, d, o);
    bit_io(op[1], d, o);
    bit_io(op[0], d, o);
    for (int i = aw() - 1; i >= 0; i--) bit_io(addr[i], d, o);
    dout = d;
    oe = o;
  endtask

  task automatic send_data(input logic [15:0] dat);
    logic d, o;
    for (int i = dw() - 1; i >= 0; i--) bit_io(dat[i], d, o);
  endtask

  task automatic wait_ready(input int exp, input string req);
    int cyc = 5;
    while (do_oe && !do_o && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(do_oe && do_o, req, "ready on data-out", {do_oe, do_o}, 2'b11);
    if (exp > 0) chk(cyc >= exp - 3 && cyc <= exp + 4, req, "busy cycles", cyc, exp);
  endtask

  task automatic do_read(input int a, input int n, input string req);
    logic d, o;
    logic [15:0] got;
    sel();
    header(2'b10, a, d, o);
    chk(o && !d, req, "leading zero bit", {o, d}, 2'b10);
    for (int w = 0; w < n; w++) begin
      got = '0;
      for (int b = 0; b < dw(); b++) begin
        bit_io(1'b0, d, o);
        got = {got[14:0], d};
      end
      chk(got == exp_word(a + w), req, $sformatf("read word at %0d", a + w), got, exp_word(a + w));
    end
    desel();
  endtask

  task automatic do_write(input int a, input logic [15:0] dat, input string req);
    logic d, o;
    sel();
    header(2'b01, a, d, o);
    send_data(dat);
    if (wen_m) begin
      put_word(a, dat);
      wait_ready(TW + 1, req);
    end else chk(!do_oe, req, "no busy while disabled", do_oe, 0);
    desel();
  endtask

  task automatic do_erase(input int a, input string req);
    logic d, o;
    sel();
    header(2'b11, a, d, o);
    if (wen_m) begin
      put_word(a, 16'hFFFF);
      wait_ready(TW + 1, req);
    end else chk(!do_oe, req, "no busy while disabled", do_oe, 0);
    desel();
  endtask

  task automatic do_ext(input logic [1:0] ex, input int low, input logic [15:0] dat, input string req);
    logic d, o;
    int addr;
    addr = (int'(ex) << (aw() - 2)) | (low & ((1 << (aw() - 2)) - 1));
    sel();
    header(2'b00, addr, d, o);
    if (ex == 2'b01) send_data(dat);
    if (ex == 2'b11) wen_m = 1;
    else if (ex == 2'b00) wen_m = 0;
    else if (!wen_m) chk(!do_oe, req, "no busy while disabled", do_oe, 0);
    else begin
      for (int i = 0; i < (1 << AW8); i++) begin
        if (ex == 2'b10) m[i] = 8'hFF;
        else m[i] = (org16 && i[0] == 1'b0) ? dat[15:8] : dat[7:0];
      end
      wait_ready((ex == 2'b10) ? TE + 1 : TA + 1, req);
    end
    desel();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic d, o;
    int a, b;
    logic [15:0] dat;
    void'($urandom(32'h1D2C3B4A));
    for (int i = 0; i < (1 << AW8); i++) m[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: idle state and erased array after reset
    chk(!do_oe, "R1", "data-out released after reset", do_oe, 0);
    do_read(5, 1, "R1");

    // R8: writes disabled after reset
    do_write(7, 16'h1234, "R8");
    do_erase(9, "R8");
    do_read(7, 1, "R8");
    do_ext(2'b11, 0, 16'h0, "R8");

    // R4 / R2: random writes read back, x16
    for (int k = 0; k < 5; k++) begin
      a = int'($urandom % 512);
      dat = 16'($urandom);
      do_write(a, dat, "R4");
      do_read(a, 1, "R2");
    end
    // R3: sequential read and wrap
    do_write(511, 16'hBEEF, "R4");
    do_write(0, 16'h0F0F, "R4");
    do_read(510, 3, "R3");
    // R5: erase a word
    do_erase(511, "R5");
    do_read(511, 1, "R5");

    // R6: erase-all with random don't-care bits
    do_ext(2'b10, int'($urandom), 16'h0, "R6");
    do_read(int'($urandom % 512), 2, "R6");
    // R7: write-all x16
    do_ext(2'b01, int'($urandom), 16'hA55A, "R7");
    do_read(int'($urandom % 512), 3, "R7");

    // x8 mode
    org16 = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      a = int'($urandom % 1024);
      dat = 16'($urandom);
      do_write(a, dat, "R4");
      do_read(a, 1, "R2");
    end
    do_write(1023, 16'h00C3, "R4");
    do_read(1022, 3, "R3");
    do_ext(2'b01, int'($urandom), 16'h003C, "R7");
    do_read(int'($urandom % 1024), 2, "R7");
    org16 = 1'b1;
    @(negedge clk);

    // R9: aborted command leaves the array alone
    a = 77;
    do_write(a, 16'h1357, "R4");
    sel();
    bit_io(1'b1, d, o); bit_io(1'b0, d, o); bit_io(1'b1, d, o);
    for (int i = 0; i < 4; i++) bit_io(1'b0, d, o);
    desel();
    do_read(a, 1, "R9");
    // R9: deselect during program cycle
    sel();
    header(2'b01, 300, d, o);
    send_data(16'h2468);
    put_word(300, 16'h2468);
    desel();
    chk(!do_oe, "R9", "released while deselected", do_oe, 0);
    sel();
    chk(do_oe && !do_o, "R9", "busy shown after reselect", {do_oe, do_o}, 2'b10);
    wait_ready(0, "R9");
    desel();
    do_read(300, 1, "R9");

    // R10 / R11: edges during busy ignored, status held until start bit
    b = 301;
    do_write(b, 16'h7777, "R4");
    sel();
    header(2'b01, 302, d, o);
    send_data(16'h5555);
    put_word(302, 16'h5555);
    header(2'b11, b, d, o);
    wait_ready(0, "R10");
    bit_io(1'b0, d, o);
    chk(o && d, "R11", "ready held over zero bits", {o, d}, 2'b11);
    bit_io(1'b0, d, o);
    chk(o && d, "R11", "ready held over zero bits", {o, d}, 2'b11);
    bit_io(1'b1, d, o);
    chk(!o, "R11", "start bit releases data-out", o, 0);
    desel();
    do_read(b, 1, "R10");
    do_read(302, 1, "R10");

    // R8: disable then whole-array ops are refused
    do_ext(2'b00, 0, 16'h0, "R8");
    do_ext(2'b10, 5, 16'h0, "R8");
    do_ext(2'b01, 5, 16'h0000, "R8");
    do_read(300, 2, "R8");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule